// File: doc/BRIEF.md
# I2C Slave Controller with 10-bit Addressing

This block is an I2C bus slave that answers to a 10-bit own address and sends data bytes back to the bus master. It takes the raw SCL and SDA levels from the pads, brings them into the system clock domain, and detects START, STOP and the edges of SCL. It pulls the lines low through two open-drain enables. A small register-style host interface sets the own address and the control bits. The host reads a status word and loads the bytes to be transmitted.

The slave follows the combined 10-bit format. A header byte of the form `11110 A9 A8 W` is followed by the low eight address bits. Once both parts have matched, the master may issue a repeated START followed by a read header (`11110 A9 A8 R`). The slave accepts that single byte as a read addressing and then transmits. It asks the host for the next byte as soon as the first bit of the current byte is on the bus. If no byte is ready when the next byte is due, it holds SCL low until one arrives. A Not Acknowledge from the master ends the transfer.

Top module: `i2c10_slave`

## Requirements
- R1: After reset both open-drain enables are 0, `irq` is 0, and `stat_dout` is `4'b0100`. The status bits are: bit 0 address match, bit 1 direction (1 = master reads), bit 2 transmit register empty, bit 3 NACK received.
- R2: While control bit 0 (enable) is 0, no header byte is acknowledged and the match flag stays 0.
- R3: With enable = 1 and control bit 1 (NAK) = 0, a write header `11110 A9 A8 0` whose A9:A8 match the own address is acknowledged. If the following byte equals own address bits 7:0, it is also acknowledged, match is set, direction is cleared to 0, and `irq` goes to 1.
- R4: A second address byte that differs from own address bits 7:0 is not acknowledged and sets no flag.
- R5: A header whose A9:A8 differ from the own address is not acknowledged.
- R6: With NAK = 1 a matching header is not acknowledged.
- R7: A status read strobe clears the match and NACK flags, unless a new match is set in the same cycle.
- R8: After a full write-address match, a repeated START followed by the read header `11110 A9 A8 1` is acknowledged on its own. It sets match and sets direction to 1.
- R9: A read header is not acknowledged unless a full 10-bit match occurred earlier in the same transfer; STOP clears that state.
- R10: In a read, the bytes placed in the data register appear on SDA MSB first, in the order they were written.
- R11: Writing the data register clears the empty flag. The empty flag is set again once the first bit of a transmitted byte has been clocked out. With control bit 2 (transmit interrupt) = 1, a set empty flag drives `irq`.
- R12: If the data register is empty when a byte is due, the slave holds SCL low until the host writes it, then releases it.
- R13: A Not Acknowledge from the master sets the NACK flag. The slave then leaves SDA released and ignores clocks until the next START.
- R14: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_wr | input | 1 | Own-address write strobe |
| addr_din | input | 10 | Own address value |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_din | input | 3 | Control: bit0 enable, bit1 NAK, bit2 transmit interrupt |
| data_wr | input | 1 | Transmit data write strobe |
| data_din | input | 8 | Transmit byte |
| stat_rd | input | 1 | Status read strobe (clears match and NACK flags) |
| stat_dout | output | 4 | Status flags |
| irq | output | 1 | Interrupt request |

## Verification
A wrong header decode or a stale 10-bit match memory shows up at the next acknowledge slot. There the master samples SDA released instead of low, or the reverse, within one bit time of the address byte. A shifter or bit counter that is off by one shows as a corrupted byte at the master. It also shows as an empty flag that rises at the wrong bit, and the bench measures that bit count in master clocks. A stuck stretch or a missed NACK holds SCL low or leaves SDA driven. The bench sees this within a few system clocks, through the bus levels and the status word.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

  // fixed prefix of a 10-bit header byte
  localparam logic [4:0] HDR_PREFIX = 5'b11110;

  // control bit positions
  localparam int CTRL_EN  = 0;
  localparam int CTRL_NAK = 1;
  localparam int CTRL_TXI = 2;

  // status bit positions
  localparam int STAT_MATCH = 0;
  localparam int STAT_RD    = 1;
  localparam int STAT_TDRE  = 2;
  localparam int STAT_NACK  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,    // ignore bus until START
    ST_RX,      // shifting in an address byte
    ST_ACK,     // holding SDA low for acknowledge
    ST_WAIT,    // fully addressed for write, waiting for repeated START
    ST_TXLOAD,  // SCL low, next byte due
    ST_TX,      // shifting a byte out
    ST_RXACK,   // sampling master acknowledge
    ST_ACKD     // acknowledged, waiting for SCL low
  } slv_state_t;

endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_now, sda_now, scl_d;

  assign scl_now = scl_pipe[STAGES-1];
  assign sda_now = sda_pipe[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  // events and sda_s are registered together so they stay aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d    <= 1'b1;
      sda_s    <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      start_ev <= 1'b0;
      stop_ev  <= 1'b0;
    end else begin
      scl_d    <= scl_now;
      sda_s    <= sda_now;
      scl_rise <= scl_now & ~scl_d;
      scl_fall <= ~scl_now & scl_d;
      start_ev <= scl_now & scl_d & sda_s & ~sda_now;
      stop_ev  <= scl_now & scl_d & ~sda_s & sda_now;
    end
  end

endmodule

// File: rtl/i2c10_regs.sv
module i2c10_regs
  import i2c10_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_din,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] ctrl_din,
  input  logic          data_wr,
  input  logic [DW-1:0] data_din,
  input  logic          stat_rd,
  input  logic          set_match,
  input  logic          match_rd,
  input  logic          set_tdre,
  input  logic          set_nack,
  output logic [AW-1:0] sla,
  output logic          en,
  output logic          nak,
  output logic          txi,
  output logic [DW-1:0] data_q,
  output logic          tdre,
  output logic          f_match,
  output logic          f_rd,
  output logic          f_nack,
  output logic          irq
);

  logic [CW-1:0] ctrl_q;

  assign en  = ctrl_q[CTRL_EN];
  assign nak = ctrl_q[CTRL_NAK];
  assign txi = ctrl_q[CTRL_TXI];

  always_ff @(posedge clk) begin
    if (rst) begin
      sla     <= '0;
      ctrl_q  <= '0;
      data_q  <= '0;
      tdre    <= 1'b1;
      f_match <= 1'b0;
      f_rd    <= 1'b0;
      f_nack  <= 1'b0;
    end else begin
      if (addr_wr) sla <= addr_din;
      if (ctrl_wr) ctrl_q <= ctrl_din;
      // a host write wins over the shifter's empty request
      if (data_wr) begin
        data_q <= data_din;
        tdre   <= 1'b0;
      end else if (set_tdre) begin
        tdre <= 1'b1;
      end
      if (set_match) begin
        f_match <= 1'b1;
        f_rd    <= match_rd;
      end else if (stat_rd) begin
        f_match <= 1'b0;
      end
      if (set_nack) f_nack <= 1'b1;
      else if (stat_rd) f_nack <= 1'b0;
    end
  end

  assign irq = en & (f_match | f_nack | (txi & tdre));

endmodule

// File: rtl/i2c10_fsm.sv
module i2c10_fsm
  import i2c10_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [AW-1:0] sla,
  input  logic          en,
  input  logic          nak,
  input  logic [DW-1:0] data_q,
  input  logic          tdre,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          set_match,
  output logic          match_rd,
  output logic          set_tdre,
  output logic          set_nack
);

  localparam int CNTW = $clog2(DW + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(DW);
  localparam logic [CNTW-1:0] ONE  = CNTW'(1);

  slv_state_t      state, after;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   shreg;
  logic            second;    // current byte is the low address byte
  logic            matched10; // full address seen in this transfer

  logic hdr_ok, low_ok, may_ack;
  assign hdr_ok  = (shreg[DW-1:DW-5] == HDR_PREFIX) && (shreg[2:1] == sla[AW-1:AW-2]);
  assign low_ok  = (shreg == sla[DW-1:0]);
  assign may_ack = en & ~nak;

  always_ff @(posedge clk) begin
    set_match <= 1'b0;
    set_tdre  <= 1'b0;
    set_nack  <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      after     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      second    <= 1'b0;
      matched10 <= 1'b0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      match_rd  <= 1'b0;
    end else if (stop_ev) begin
      state     <= ST_IDLE;
      matched10 <= 1'b0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_RX;
      cnt    <= '0;
      second <= 1'b0;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && cnt != FULL) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + ONE;
          end else if (scl_fall && cnt == FULL) begin
            if (!second) begin
              if (may_ack && hdr_ok && (!shreg[0] || matched10)) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (shreg[0]) begin
                  set_match <= 1'b1;
                  match_rd  <= 1'b1;
                  after     <= ST_TXLOAD;
                end else begin
                  second <= 1'b1;
                  after  <= ST_RX;
                end
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              if (may_ack && low_ok) begin
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                set_match <= 1'b1;
                match_rd  <= 1'b0;
                matched10 <= 1'b1;
                after     <= ST_WAIT;
              end else begin
                matched10 <= 1'b0;
                state     <= ST_IDLE;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= after;
          end
        end
        ST_TXLOAD: begin
          if (!tdre) begin
            // drive MSB now; SCL is released on the next cycle
            shreg  <= data_q;
            sda_oe <= ~data_q[DW-1];
            cnt    <= '0;
            state  <= ST_TX;
          end else begin
            scl_oe <= 1'b1;
          end
        end
        ST_TX: begin
          scl_oe <= 1'b0;
          if (scl_rise) cnt <= cnt + ONE;
          if (scl_fall) begin
            if (cnt == ONE) set_tdre <= 1'b1;
            if (cnt == FULL) begin
              sda_oe <= 1'b0;
              state  <= ST_RXACK;
            end else begin
              shreg  <= {shreg[DW-2:0], 1'b0};
              sda_oe <= ~shreg[DW-2];
            end
          end
        end
        ST_RXACK: begin
          if (scl_rise) begin
            if (sda_s) begin
              set_nack <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              state <= ST_ACKD;
            end
          end
        end
        ST_ACKD: begin
          if (scl_fall) state <= ST_TXLOAD;
        end
        default: ; // ST_IDLE, ST_WAIT: wait for START or STOP
      endcase
    end
  end

endmodule

// File: rtl/i2c10_slave.sv
module i2c10_slave
  import i2c10_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DW      = 8,
  parameter int CW      = 3,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_din,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] ctrl_din,
  input  logic          data_wr,
  input  logic [DW-1:0] data_din,
  input  logic          stat_rd,
  output logic [3:0]    stat_dout,
  output logic          irq
);

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [AW-1:0] sla;
  logic ctrl_en, ctrl_nak, ctrl_txi;
  logic [DW-1:0] data_q;
  logic tdre, f_match, f_rd, f_nack;
  logic fsm_set_match, fsm_match_rd, fsm_set_tdre, fsm_set_nack;

  i2c10_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c10_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .addr_wr(addr_wr), .addr_din(addr_din),
    .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din),
    .data_wr(data_wr), .data_din(data_din),
    .stat_rd(stat_rd),
    .set_match(fsm_set_match), .match_rd(fsm_match_rd),
    .set_tdre(fsm_set_tdre), .set_nack(fsm_set_nack),
    .sla(sla), .en(ctrl_en), .nak(ctrl_nak), .txi(ctrl_txi),
    .data_q(data_q), .tdre(tdre),
    .f_match(f_match), .f_rd(f_rd), .f_nack(f_nack), .irq(irq)
  );

  i2c10_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .sla(sla), .en(ctrl_en), .nak(ctrl_nak),
    .data_q(data_q), .tdre(tdre),
    .sda_oe(sda_oe), .scl_oe(scl_oe),
    .set_match(fsm_set_match), .match_rd(fsm_match_rd),
    .set_tdre(fsm_set_tdre), .set_nack(fsm_set_nack)
  );

  always_comb begin
    stat_dout             = '0;
    stat_dout[STAT_MATCH] = f_match;
    stat_dout[STAT_RD]    = f_rd;
    stat_dout[STAT_TDRE]  = tdre;
    stat_dout[STAT_NACK]  = f_nack;
  end

  // transmit interrupt enable is only consumed by the irq term
  logic unused_txi;
  assign unused_txi = ctrl_txi;

endmodule

// File: rtl/i2c10_checker.sv
module i2c10_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       data_wr,
  input logic       stat_rd,
  input logic [3:0] stat,
  input logic       en,
  input logic       set_match
);

  assert_sda_moves_scl_low_R14: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  assert_stretch_only_empty_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> $past(stat[2]));

  assert_write_fills_R11: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !stat[2]);

  assert_read_clears_match_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !set_match) |=> !stat[0]);

  assert_nack_releases_sda_R13: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[3]) |-> !sda_oe);

  assert_disabled_no_match_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(en, 2)) |-> !$rose(stat[0]));

  assert_read_dir_with_match_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[1]) |-> stat[0]);

endmodule

bind i2c10_slave i2c10_checker u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .data_wr(data_wr), .stat_rd(stat_rd), .stat(stat_dout),
  .en(ctrl_en), .set_match(fsm_set_match)
);

// File: tb/sim_i2c10_slave.sv
module sim_i2c10_slave;

  localparam int CLK_P = 10;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  wire  scl_oe, sda_oe;
  wire  scl_bus = m_scl & ~scl_oe;
  wire  sda_bus = m_sda & ~sda_oe;
  logic addr_wr = 0, ctrl_wr = 0, data_wr = 0, stat_rd = 0;
  logic [9:0] addr_din = '0;
  logic [2:0] ctrl_din = '0;
  logic [7:0] data_din = '0;
  wire  [3:0] stat_dout;
  wire  irq;

  int compared = 0, mismatched = 0, bits_seen = 0, r14_bad = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  i2c10_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .addr_wr(addr_wr), .addr_din(addr_din),
    .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din),
    .data_wr(data_wr), .data_din(data_din),
    .stat_rd(stat_rd), .stat_dout(stat_dout), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R14 monitor: slave SDA changes must land while SCL is low
  always @(negedge clk) begin
    if (!rst && sda_oe !== prev_oe && scl_bus) r14_bad++;
    prev_oe = sda_oe;
  end

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bit_cycle(input logic b, output logic r);
    m_sda = b; qwait();
    m_scl = 1'b1;
    do @(negedge clk); while (!scl_bus);
    qwait(); r = sda_bus; qwait();
    m_scl = 1'b0; bits_seen++; qwait();
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic m_restart();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b1; qwait();
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_cycle(v[i], r);
    bit_cycle(1'b1, r);
    ack = ~r;
  endtask

  // monitor side of the scoreboard: pop the expected byte and compare
  task automatic read_byte(input logic nack);
    logic r;
    logic [7:0] v;
    v = '0;
    bits_seen = 0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, r);
      v = {v[6:0], r};
    end
    bit_cycle(nack, r);
    if (exp_q.size() == 0) chk("R10 queue empty", 32'(v), 32'hFFFF);
    else chk("R10 byte", 32'(v), 32'(exp_q.pop_front()));
  endtask

  task automatic h_addr(input logic [9:0] v);
    @(negedge clk); addr_wr = 1; addr_din = v; @(negedge clk); addr_wr = 0;
  endtask
  task automatic h_ctrl(input logic [2:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_din = v; @(negedge clk); ctrl_wr = 0;
  endtask
  // driver side of the scoreboard
  task automatic h_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1; data_din = v; exp_q.push_back(v);
    @(negedge clk); data_wr = 0;
  endtask
  task automatic h_stat_rd();
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic ack;
    logic r;
    logic [7:0] raw;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl_oe", 32'(scl_oe), 0);
    chk("R1 sda_oe", 32'(sda_oe), 0);
    chk("R1 stat", 32'(stat_dout), 32'h4);
    chk("R1 irq", 32'(irq), 0);

    h_addr(10'h2B5);

    // R2: disabled
    m_start(); write_byte(8'hF4, ack); m_stop();
    chk("R2 ack", 32'(ack), 0);
    chk("R2 stat", 32'(stat_dout), 32'h4);

    h_ctrl(3'b001);

    // R5: wrong upper address bits
    m_start(); write_byte(8'hF2, ack); m_stop();
    chk("R5 ack", 32'(ack), 0);

    // R3: full write addressing
    m_start();
    write_byte(8'hF4, ack); chk("R3 hdr ack", 32'(ack), 1);
    write_byte(8'hB5, ack); chk("R3 low ack", 32'(ack), 1);
    chk("R3 stat", 32'(stat_dout), 32'h5);
    chk("R3 irq", 32'(irq), 1);
    h_stat_rd();
    chk("R7 stat", 32'(stat_dout), 32'h4);
    chk("R7 irq", 32'(irq), 0);
    m_stop();

    // R9: read header after STOP
    m_start(); write_byte(8'hF5, ack); m_stop();
    chk("R9 ack", 32'(ack), 0);
    chk("R9 stat", 32'(stat_dout), 32'h4);

    // R4: wrong low byte
    m_start();
    write_byte(8'hF4, ack); chk("R4 hdr ack", 32'(ack), 1);
    write_byte(8'hB4, ack); chk("R4 low ack", 32'(ack), 0);
    m_stop();
    chk("R4 stat", 32'(stat_dout), 32'h4);

    // R6: NAK set
    h_ctrl(3'b011);
    m_start(); write_byte(8'hF4, ack); m_stop();
    chk("R6 ack", 32'(ack), 0);
    h_ctrl(3'b001);

    // R8: combined format
    m_start();
    write_byte(8'hF4, ack);
    write_byte(8'hB5, ack); chk("R8 write part ack", 32'(ack), 1);
    h_stat_rd();
    h_data(8'hA5);
    chk("R11 filled", 32'(stat_dout), 32'h0);
    h_ctrl(3'b101);
    chk("R11 irq low while full", 32'(irq), 0);
    m_restart();
    write_byte(8'hF5, ack); chk("R8 read hdr ack", 32'(ack), 1);
    chk("R8 stat", 32'(stat_dout), 32'h3);
    h_stat_rd();
    chk("R7 rd kept", 32'(stat_dout), 32'h2);

    // R10/R11: first byte, next requested after one bit
    fork
      read_byte(1'b0);
      begin
        do @(negedge clk); while (!stat_dout[2]);
        chk("R11 bits at empty", 32'(bits_seen), 1);
        chk("R11 irq", 32'(irq), 1);
        h_data(8'h3C);
      end
    join
    read_byte(1'b0);

    // R12: stretch until data arrives; master NACKs this byte
    fork
      read_byte(1'b1);
      begin
        repeat (80) @(negedge clk);
        chk("R12 scl held", 32'(scl_oe), 1);
        chk("R12 bus low", 32'(scl_bus), 0);
        h_data(8'h81);
        repeat (20) @(negedge clk);
        chk("R12 released", 32'(scl_oe), 0);
      end
    join
    chk("R13 stat", 32'(stat_dout), 32'hE);
    chk("R13 irq", 32'(irq), 1);
    chk("R13 sda free", 32'(sda_oe), 0);
    raw = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, r);
      raw = {raw[6:0], r};
    end
    chk("R13 idle byte", 32'(raw), 32'hFF);
    m_stop();
    h_stat_rd();
    chk("R7 nack cleared", 32'(stat_dout), 32'h6);
    chk("R14 sda moves", 32'(r14_bad), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule